// File: doc/BRIEF.md
# Modem Handshake Status and Loopback Unit

This block sits beside the line controller of a 16550-style serial port. It drives four handshake outputs: data terminal ready, request to send, and two general-purpose outputs. These come from a modem control byte. The block also samples four handshake inputs: carrier detect, ring indication, data set ready and clear to send. It passes them through a synchronizer and presents them, together with change flags, as a status byte. A single change signal tells the interrupt unit that at least one change flag is pending. A read strobe from the register interface clears the change flags.

A loopback bit in the control byte disconnects the block from the outside world. The control outputs are then fed crosswise onto the status inputs. The transmitter's serial output is returned to the receiver input. The external serial output rests at mark and the external handshake outputs go inactive. Polarity inversion of the pins and interrupt prioritisation are handled elsewhere. All signals here are active high.

Top module: `mdm_ctrl`

## Requirements
- R1: While reset is asserted (rst_n low), status_o is 8'h00, chg_o is 0, and after release no change flag sets until a line actually changes.
- R2: With control bit 4 clear, dtr_o, rts_o, out1_o and out2_o follow control bits 0, 1, 2 and 3. txd_pin_o follows txd_i and rxd_o follows rxd_pin_i.
- R3: With loopback clear, status bits 7, 6, 5 and 4 show carrier detect, ring, data set ready and clear to send. Each follows its input pin three clock edges after the pin changes (two synchronizer stages and one status register).
- R4: Status bit 3 (carrier), bit 1 (data set ready) and bit 0 (clear to send) set whenever the matching line's registered value changes in either direction.
- R5: Status bit 2 sets only when the ring line goes from 1 to 0. A 0-to-1 ring transition does not set it.
- R6: A clock edge with stat_rd_i high clears all four change bits (3:0), unless R7 applies.
- R7: A change that is detected on the same edge as a read sets its bit instead of being lost.
- R8: With control bit 4 set, status bits 7..4 take OUT2 (bit 3), OUT1 (bit 2), DTR (bit 0) and RTS (bit 1) one edge after the control byte is applied. The external handshake pins have no effect.
- R9: With control bit 4 set, rxd_o equals txd_i, txd_pin_o is 1, the four handshake outputs are 0, and rxd_pin_i has no effect.
- R10: chg_o is 1 exactly when any of status bits 3..0 is 1.
- R11: Control bits 7..5 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_i | input | 8 | Modem control byte (bit 4 = loopback) |
| stat_rd_i | input | 1 | Status byte read strobe, one cycle per read |
| dcd_i | input | 1 | External carrier detect |
| ri_i | input | 1 | External ring indication |
| dsr_i | input | 1 | External data set ready |
| cts_i | input | 1 | External clear to send |
| txd_i | input | 1 | Serial output from the transmitter |
| rxd_pin_i | input | 1 | External serial input |
| dtr_o | output | 1 | External data terminal ready |
| rts_o | output | 1 | External request to send |
| out1_o | output | 1 | External general output 1 |
| out2_o | output | 1 | External general output 2 |
| txd_pin_o | output | 1 | External serial output |
| rxd_o | output | 1 | Serial input to the receiver |
| status_o | output | 8 | Modem status byte |
| chg_o | output | 1 | Any change flag pending |

## Verification
The bench targets the ring edge direction. A design that flags any ring change would set bit 2 on the rising edge, and one that picks the wrong direction would miss the falling edge. It times a line change so that it lands on the same edge as a read; a design that gives the read priority silently loses that change. It checks loopback with the external pins held opposite to the control bits. A wrong crosswise mapping or a leak from the pins shows up as swapped or stale status bits, and the pin latency is checked at exactly three edges so that a missing or extra synchronizer stage is caught.

// File: rtl/mdm_pkg.sv
package mdm_pkg;

  typedef struct packed {
    logic dcd;
    logic ri;
    logic dsr;
    logic cts;
  } lines_t;

  localparam int CtlDtr  = 0;
  localparam int CtlRts  = 1;
  localparam int CtlOut1 = 2;
  localparam int CtlOut2 = 3;
  localparam int CtlLoop = 4;

  localparam int NumLines = 4;

  // Crosswise feedback of the control outputs onto the status inputs.
  function automatic lines_t loop_map(input logic [7:0] ctl);
    lines_t l;
    l.dcd = ctl[CtlOut2];
    l.ri  = ctl[CtlOut1];
    l.dsr = ctl[CtlDtr];
    l.cts = ctl[CtlRts];
    return l;
  endfunction

  // Change events in status bit order {dcd, ri trailing, dsr, cts}.
  function automatic logic [NumLines-1:0] line_events(input lines_t prv,
                                                      input lines_t cur);
    return {prv.dcd ^ cur.dcd,
            prv.ri & ~cur.ri,
            prv.dsr ^ cur.dsr,
            prv.cts ^ cur.cts};
  endfunction

  // Read clears, coincident events win.
  function automatic logic [NumLines-1:0] delta_next(input logic [NumLines-1:0] cur,
                                                     input logic rd,
                                                     input logic [NumLines-1:0] ev);
    return (rd ? '0 : cur) | ev;
  endfunction

endpackage

// File: rtl/mdm_sync.sv
module mdm_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= '0;
    else        stg[0] <= d_i;
  end

  generate
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= '0;
        else        stg[s] <= stg[s-1];
      end
    end
  endgenerate

  assign q_o = stg[STAGES-1];

endmodule

// File: rtl/mdm_loop.sv
module mdm_loop
  import mdm_pkg::*;
(
  input  logic [7:0] ctrl_i,
  input  lines_t     ext_sync_i,
  input  logic       txd_i,
  input  logic       rxd_pin_i,
  output lines_t     lines_o,
  output logic       dtr_o,
  output logic       rts_o,
  output logic       out1_o,
  output logic       out2_o,
  output logic       txd_pin_o,
  output logic       rxd_o
);

  logic loop_en;
  assign loop_en = ctrl_i[CtlLoop];

  always_comb begin
    if (loop_en) begin
      lines_o   = loop_map(ctrl_i);
      dtr_o     = 1'b0;
      rts_o     = 1'b0;
      out1_o    = 1'b0;
      out2_o    = 1'b0;
      txd_pin_o = 1'b1;
      rxd_o     = txd_i;
    end else begin
      lines_o   = ext_sync_i;
      dtr_o     = ctrl_i[CtlDtr];
      rts_o     = ctrl_i[CtlRts];
      out1_o    = ctrl_i[CtlOut1];
      out2_o    = ctrl_i[CtlOut2];
      txd_pin_o = txd_i;
      rxd_o     = rxd_pin_i;
    end
  end

endmodule

// File: rtl/mdm_status.sv
module mdm_status
  import mdm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  lines_t     lines_i,
  input  logic       rd_i,
  output logic [7:0] status_o,
  output logic       chg_o,
  output logic [NumLines-1:0] evt_o
);

  lines_t                lines_q;
  logic [NumLines-1:0]   delta_q;
  logic [NumLines-1:0]   evt;

  assign evt   = line_events(lines_q, lines_i);
  assign evt_o = evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lines_q <= '0;
      delta_q <= '0;
    end else begin
      lines_q <= lines_i;
      delta_q <= delta_next(delta_q, rd_i, evt);
    end
  end

  assign status_o = {lines_q, delta_q};
  assign chg_o    = |delta_q;

  // R6: a read with no coincident event leaves no change bit set
  a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && evt == '0) |=> (delta_q == '0));

  // R7: a detected event is always present after the edge
  a_r7_event_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (evt != '0) |=> ((delta_q & $past(evt)) == $past(evt)));

  // R5: a rising ring line never sets the trailing-edge bit
  a_r5_ri_rise_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!lines_q.ri && lines_i.ri && !delta_q[2]) |=> !delta_q[2]);

  // R10: the change flag can only rise after a detected event
  a_r10_flag_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chg_o) |-> $past(evt != '0));

endmodule

// File: rtl/mdm_ctrl.sv
module mdm_ctrl
  import mdm_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] ctrl_i,
  input  logic       stat_rd_i,
  input  logic       dcd_i,
  input  logic       ri_i,
  input  logic       dsr_i,
  input  logic       cts_i,
  input  logic       txd_i,
  input  logic       rxd_pin_i,
  output logic       dtr_o,
  output logic       rts_o,
  output logic       out1_o,
  output logic       out2_o,
  output logic       txd_pin_o,
  output logic       rxd_o,
  output logic [7:0] status_o,
  output logic       chg_o
);

  lines_t              ext_raw;
  lines_t              ext_sync;
  lines_t              lines_sel;
  logic [NumLines-1:0] evt_w;

  assign ext_raw = '{dcd: dcd_i, ri: ri_i, dsr: dsr_i, cts: cts_i};

  mdm_sync #(.WIDTH(NumLines), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (ext_raw),
    .q_o   (ext_sync)
  );

  mdm_loop u_loop (
    .ctrl_i     (ctrl_i),
    .ext_sync_i (ext_sync),
    .txd_i      (txd_i),
    .rxd_pin_i  (rxd_pin_i),
    .lines_o    (lines_sel),
    .dtr_o      (dtr_o),
    .rts_o      (rts_o),
    .out1_o     (out1_o),
    .out2_o     (out2_o),
    .txd_pin_o  (txd_pin_o),
    .rxd_o      (rxd_o)
  );

  mdm_status u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .lines_i  (lines_sel),
    .rd_i     (stat_rd_i),
    .status_o (status_o),
    .chg_o    (chg_o),
    .evt_o    (evt_w)
  );

  // R8: held loopback shows the previous control byte, crosswise
  a_r8_loop_status: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ctrl_i[CtlLoop]) |-> (status_o[7:4] == loop_map($past(ctrl_i))));

  // R9: loopback keeps the line idle and the handshake outputs low
  a_r9_loop_pins: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_i[CtlLoop] |-> (txd_pin_o && !dtr_o && !rts_o && !out1_o && !out2_o
                         && rxd_o == txd_i));

  // R10: pending flag agrees with the status byte
  a_r10_flag_match: assert property (@(posedge clk) disable iff (!rst_n)
    chg_o == (status_o[3:0] != 4'h0));

endmodule

// File: tb/mdm_ctrl_bench.sv
module mdm_ctrl_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] ctrl = 8'h00;
  logic       rd = 1'b0;
  logic       dcd = 1'b0, ri = 1'b0, dsr = 1'b0, cts = 1'b0;
  logic       txd = 1'b1, rxp = 1'b1;
  logic       dtr_o, rts_o, out1_o, out2_o, txd_pin_o, rxd_o, chg_o;
  logic [7:0] status_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  mdm_ctrl u_mdm_ctrl (
    .clk(clk), .rst_n(rst_n), .ctrl_i(ctrl), .stat_rd_i(rd),
    .dcd_i(dcd), .ri_i(ri), .dsr_i(dsr), .cts_i(cts),
    .txd_i(txd), .rxd_pin_i(rxp),
    .dtr_o(dtr_o), .rts_o(rts_o), .out1_o(out1_o), .out2_o(out2_o),
    .txd_pin_o(txd_pin_o), .rxd_o(rxd_o), .status_o(status_o), .chg_o(chg_o)
  );

  // Reference: line values listed {dcd, ri, dsr, cts}
  logic [3:0] m_s1, m_s2, m_lq, m_d;

  function automatic logic [3:0] exp_lines(logic [7:0] c, logic [3:0] pins);
    if (c[4]) return {c[3], c[2], c[0], c[1]};
    return pins;
  endfunction

  function automatic logic [3:0] exp_events(logic [3:0] old, logic [3:0] nw);
    logic [3:0] e;
    e[3] = old[3] != nw[3];
    e[2] = old[2] && !nw[2];
    e[1] = old[1] != nw[1];
    e[0] = old[0] != nw[0];
    return e;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= 4'h0; m_s2 <= 4'h0; m_lq <= 4'h0; m_d <= 4'h0;
    end else begin
      m_s1 <= {dcd, ri, dsr, cts};
      m_s2 <= m_s1;
      m_lq <= exp_lines(ctrl, m_s2);
      m_d  <= (rd ? 4'h0 : m_d) | exp_events(m_lq, exp_lines(ctrl, m_s2));
    end
  end

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic check_model(string req);
    logic [5:0] pins_exp;
    chk({req, " status"}, status_o, {m_lq, m_d});
    chk({req, " R10 flag"}, {7'd0, chg_o}, {7'd0, |m_d});
    if (ctrl[4]) pins_exp = {4'b0000, 1'b1, txd};
    else         pins_exp = {ctrl[0], ctrl[1], ctrl[2], ctrl[3], txd, rxp};
    chk({req, " R2/R9 pins"}, {2'b00, dtr_o, rts_o, out1_o, out2_o, txd_pin_o, rxd_o},
        {2'b00, pins_exp});
  endtask

  task automatic cyc(string req);
    @(negedge clk);
    check_model(req);
  endtask

  task automatic clear_all();
    rd = 1'b1; cyc("R6"); rd = 1'b0;
  endtask

  initial begin
    #(20 * 150000);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    if (!done) begin
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    // R1: reset state
    dcd = 1'b1; ri = 1'b1; cts = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 reset status", status_o, 8'h00);
    chk("R1 reset flag", {7'd0, chg_o}, 8'h00);
    dcd = 1'b0; ri = 1'b0; cts = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    repeat (4) cyc("R1");
    chk("R1 no spurious change", status_o, 8'h00);

    // R3/R4: latency of exactly three edges
    dsr = 1'b1;
    cyc("R3"); cyc("R3");
    chk("R3 not yet after two edges", status_o, 8'h00);
    cyc("R3");
    chk("R3/R4 dsr seen on third edge", status_o, 8'h22);
    clear_all();
    chk("R6 read clears", status_o, 8'h20);

    // R5: ring rising does not flag, falling does
    ri = 1'b1; repeat (4) cyc("R5");
    chk("R5 rising ring quiet", status_o, 8'h60);
    ri = 1'b0; repeat (4) cyc("R5");
    chk("R5 falling ring flags", status_o, 8'h24);
    clear_all();

    // R7: change lands on the same edge as a read
    cts = 1'b1; cyc("R7"); cyc("R7");
    dcd = 1'b1;
    rd = 1'b1; cyc("R7"); rd = 1'b0;
    chk("R7 coincident change kept", status_o, 8'h31);
    repeat (3) cyc("R4");
    chk("R4 dcd flagged", status_o, 8'hb9);
    clear_all();

    // R8/R9/R11: loopback with pins held opposite
    dcd = 1'b0; ri = 1'b1; dsr = 1'b0; cts = 1'b0; rxp = 1'b0;
    repeat (4) cyc("R8");
    clear_all();
    ctrl = 8'hf0 | 8'h0b;  // loop, DTR, RTS, OUT2, upper bits set
    txd = 1'b0;
    cyc("R8");
    chk("R8 crosswise map", status_o[7:4], 8'h0b);
    chk("R9 pins in loopback", {dtr_o, rts_o, out1_o, out2_o, txd_pin_o, rxd_o}, 8'h02);
    ri = 1'b0; dsr = 1'b1; rxp = 1'b1;
    repeat (4) cyc("R9");
    chk("R8 pins ignored", status_o[7:4], 8'h0b);
    chk("R9 rxd from tx", {7'd0, rxd_o}, 8'h00);
    ctrl = 8'h10; cyc("R8");
    chk("R8 out2 drop flags dcd", status_o[3], 8'h01);
    ctrl = 8'h00; repeat (4) cyc("R8");
    clear_all();

    // R11: upper control bits do nothing in normal mode
    ctrl = 8'he5; cyc("R11");
    chk("R11 upper bits ignored", {dtr_o, rts_o, out1_o, out2_o}, 8'h0a);

    // Random mix
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 7) == 0) ctrl = 8'($urandom);
      else if ($urandom_range(0, 15) == 0) ctrl[4] = 1'b0;
      {dcd, ri, dsr, cts} = ($urandom_range(0, 3) == 0) ? 4'($urandom) : {dcd, ri, dsr, cts};
      txd = 1'($urandom); rxp = 1'($urandom);
      rd  = ($urandom_range(0, 3) == 0);
      cyc("R3 R4 R6 R7 random");
    end
    rd = 1'b0;

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule